// File: doc/BRIEF.md
# Approximate Cache Line Bit-Flip Injector

This block corrupts cache lines on purpose, in order to model storage that trades accuracy for density. Each incoming line comes with a flag that marks it as approximate or precise, the time it was last touched, the current time, a path selector (cache or memory) and enables for two error modes. The block returns the line with some of its bits inverted, and it also returns the mask of inverted bits. Precise lines always come back unchanged.

The unit has one pseudo-random lane per bit of the line. Each lane is a 32-bit maximal-length LFSR. A bit is inverted when its lane value is at or below a threshold. The threshold is built from two parts. The time-independent part is inversely proportional to an error parameter. The time-dependent part grows with the time since the line was last touched, multiplied by a slope. The sum of the two parts saturates at the full scale. The time-independent part applies only on the cache path. The time-dependent part applies on both the cache path and the memory path.

Top module: `approx_flip_inj`

## Requirements
- R1: Every accepted input (valid_i high) produces exactly one result with valid_o high, two clock edges later. Results come out in input order, and inputs may arrive on back-to-back cycles.
- R2: line_o always equals the accepted line XOR mask_o. While valid_o is low, mask_o is zero.
- R3: When approx_i is 0 (precise line), mask_o is zero, whatever the mode, the parameter or the times.
- R4: Each lane is a 32-bit Galois LFSR with polynomial x^32+x^22+x^2+x+1, and its state is never zero. A bit flips when its lane value is less than or equal to the threshold. A threshold of 0 therefore never flips a bit, and a threshold of 2^32-1 flips every bit.
- R5: The time-independent part of the threshold is floor((2^32-1)/err_param_i), and an err_param_i of 0 counts as full scale. This gives the following:
  - err_param_i of 0 or 1 flips every bit.
  - err_param_i of 2 flips about half the bits.
  - err_param_i of 8 flips about one bit in eight.
- R6: The time-independent part applies only when static_en_i is 1 and path_i is 0 (cache). On path_i 1 (memory) it contributes nothing.
- R7: When dyn_en_i is 1, the threshold gains ((now_i - last_i) mod 2^16) * slope_i, so a wrapped time stamp still gives a small positive age. The total saturates at 2^32-1.
- R8: The time-dependent part applies on both paths. With an age of 0 it adds nothing.
- R9: When both static_en_i and dyn_en_i are 0, mask_o is zero.
- R10: During and right after reset, valid_o, line_o and mask_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input line valid |
| line_i | input | LINE_W | Line data |
| approx_i | input | 1 | 1 = approximate line, 0 = precise |
| path_i | input | 1 | 0 = cache access, 1 = memory-resident access |
| static_en_i | input | 1 | Enable time-independent errors |
| dyn_en_i | input | 1 | Enable time-dependent errors |
| err_param_i | input | PARAM_W | Error parameter (larger means rarer flips) |
| last_i | input | TS_W | Time stamp of the last touch |
| now_i | input | TS_W | Current time stamp |
| slope_i | input | 32 | Threshold increase per time unit of age |
| valid_o | output | 1 | Result valid |
| line_o | output | LINE_W | Line after injection |
| mask_o | output | LINE_W | Bits that were inverted |

## Verification
The bench drives the threshold to its two extremes, where the outcome is certain. It checks three cases:
- A precise line with the most aggressive setting. A design that ignored the flag would return a fully inverted line.
- The memory path with only the time-independent mode enabled. A design that did not gate that mode by path would flip bits there.
- A time stamp that has wrapped, combined with a saturating slope. A design that computed the age as signed or without the modulo would produce no flips instead of flipping every bit.

Flip counts gathered over hundreds of lines confirm the inverse dependence on the parameter and the growth with age. A design that divided the wrong way round, or that dropped the saturation, would land outside the accepted bands.

// File: rtl/approx_flip_pkg.sv
package approx_flip_pkg;
  localparam int unsigned RNG_W = 32;
  localparam logic [RNG_W-1:0] RNG_POLY = 32'h8020_0003;
  localparam logic [RNG_W-1:0] THR_MAX = '1;
  typedef logic [RNG_W-1:0] thr_t;

  function automatic thr_t lane_seed(input thr_t base, input int unsigned idx);
    thr_t s;
    s = base ^ (thr_t'(idx + 1) * 32'h9E37_79B9);
    s = {s[12:0], s[31:13]};
    if (s == '0) s = 32'h1;
    return s;
  endfunction
endpackage

// File: rtl/approx_flip_lane.sv
module approx_flip_lane
  import approx_flip_pkg::*;
#(
  parameter thr_t SEED = 32'h1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  output thr_t state_o
);
  thr_t state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else if (adv_i) state_q <= (state_q >> 1) ^ (state_q[0] ? RNG_POLY : '0);
  end

  assign state_o = state_q;
endmodule

// File: rtl/approx_flip_thresh.sv
module approx_flip_thresh
  import approx_flip_pkg::*;
#(
  parameter int unsigned PARAM_W = 16,
  parameter int unsigned TS_W    = 16
) (
  input  logic [PARAM_W-1:0] err_param_i,
  input  logic [TS_W-1:0]    last_i,
  input  logic [TS_W-1:0]    now_i,
  input  thr_t               slope_i,
  input  logic               static_act_i,
  input  logic               dyn_act_i,
  output thr_t               thr_o
);
  localparam int unsigned PROD_W = TS_W + RNG_W;
  localparam int unsigned SUM_W  = PROD_W + 1;

  thr_t              base;
  logic [TS_W-1:0]   age;
  logic [PROD_W-1:0] ramp;
  logic [SUM_W-1:0]  total;

  always_comb begin
    base  = (err_param_i == '0) ? THR_MAX : THR_MAX / thr_t'(err_param_i);
    age   = now_i - last_i;  // modular age tolerates stamp wrap
    ramp  = PROD_W'(age) * PROD_W'(slope_i);
    total = (static_act_i ? SUM_W'(base) : '0) + (dyn_act_i ? SUM_W'(ramp) : '0);
    thr_o = (total > SUM_W'(THR_MAX)) ? THR_MAX : total[RNG_W-1:0];
  end
endmodule

// File: rtl/approx_flip_inj.sv
module approx_flip_inj
  import approx_flip_pkg::*;
#(
  parameter int unsigned LINE_W  = 32,
  parameter int unsigned PARAM_W = 16,
  parameter int unsigned TS_W    = 16,
  parameter thr_t        SEED    = 32'hACE1_2468
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [LINE_W-1:0]  line_i,
  input  logic               approx_i,
  input  logic               path_i,
  input  logic               static_en_i,
  input  logic               dyn_en_i,
  input  logic [PARAM_W-1:0] err_param_i,
  input  logic [TS_W-1:0]    last_i,
  input  logic [TS_W-1:0]    now_i,
  input  logic [31:0]        slope_i,
  output logic               valid_o,
  output logic [LINE_W-1:0]  line_o,
  output logic [LINE_W-1:0]  mask_o
);
  thr_t              thr_d, s1_thr_q;
  logic              s1_valid_q;
  logic [LINE_W-1:0] s1_line_q, mask_d;
  logic              static_act, dyn_act;

  assign static_act = approx_i & static_en_i & ~path_i;
  assign dyn_act    = approx_i & dyn_en_i;

  approx_flip_thresh #(.PARAM_W(PARAM_W), .TS_W(TS_W)) u_thresh (
    .err_param_i (err_param_i),
    .last_i      (last_i),
    .now_i       (now_i),
    .slope_i     (slope_i),
    .static_act_i(static_act),
    .dyn_act_i   (dyn_act),
    .thr_o       (thr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_line_q  <= '0;
      s1_thr_q   <= '0;
    end else begin
      s1_valid_q <= valid_i;
      if (valid_i) begin
        s1_line_q <= line_i;
        s1_thr_q  <= thr_d;
      end
    end
  end

  for (genvar g = 0; g < LINE_W; g++) begin : g_lane
    thr_t lane_val;
    approx_flip_lane #(.SEED(lane_seed(SEED, g))) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .adv_i  (s1_valid_q),
      .state_o(lane_val)
    );
    assign mask_d[g] = (lane_val <= s1_thr_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      line_o  <= '0;
      mask_o  <= '0;
    end else begin
      valid_o <= s1_valid_q;
      mask_o  <= s1_valid_q ? mask_d : '0;
      line_o  <= s1_valid_q ? (s1_line_q ^ mask_d) : '0;
    end
  end
endmodule

// File: rtl/approx_flip_inj_chk.sv
module approx_flip_inj_chk #(
  parameter int unsigned LINE_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [LINE_W-1:0] line_i,
  input logic              approx_i,
  input logic              path_i,
  input logic              static_en_i,
  input logic              dyn_en_i,
  input logic              valid_o,
  input logic [LINE_W-1:0] line_o,
  input logic [LINE_W-1:0] mask_o
);
  assert_latency_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##2 valid_o);

  assert_line_xor_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##2 ((line_o ^ mask_o) == $past(line_i, 2)));

  assert_idle_mask_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (mask_o == '0));

  assert_precise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !approx_i) |-> ##2 (mask_o == '0));

  assert_mem_static_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && path_i && !dyn_en_i) |-> ##2 (mask_o == '0));

  assert_no_mode_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !static_en_i && !dyn_en_i) |-> ##2 (mask_o == '0));
endmodule

bind approx_flip_inj approx_flip_inj_chk #(.LINE_W(LINE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .line_i(line_i),
  .approx_i(approx_i), .path_i(path_i), .static_en_i(static_en_i),
  .dyn_en_i(dyn_en_i), .valid_o(valid_o), .line_o(line_o), .mask_o(mask_o)
);

// File: tb/approx_flip_inj_bench.sv
module approx_flip_inj_bench;
  localparam int LW = 32;
  localparam int KIND_ANY = 0, KIND_ZERO = 1, KIND_ONES = 2;

  typedef struct {
    logic [LW-1:0] line;
    int            kind;
    int            cyc;
    string         req;
  } exp_t;

  logic          clk = 0, rst_n = 0;
  logic          valid_i = 0, approx_i = 0, path_i = 0, st_en = 0, dy_en = 0;
  logic [LW-1:0] line_i = '0;
  logic [15:0]   param_i = '0, last_i = '0, now_i = '0;
  logic [31:0]   slope_i = '0;
  logic          valid_o;
  logic [LW-1:0] line_o, mask_o;

  int n_chk = 0, n_bad = 0, cyc = 0, flip_acc = 0;
  exp_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  approx_flip_inj u_approx_flip_inj (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .line_i(line_i),
    .approx_i(approx_i), .path_i(path_i), .static_en_i(st_en), .dyn_en_i(dy_en),
    .err_param_i(param_i), .last_i(last_i), .now_i(now_i), .slope_i(slope_i),
    .valid_o(valid_o), .line_o(line_o), .mask_o(mask_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (q.size() == 0) begin
        check(0, "R1", "unexpected result", 64'(valid_o), 64'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(cyc - e.cyc == 2, "R1", "latency", 64'(cyc - e.cyc), 64'd2);
        check((line_o ^ mask_o) == e.line, "R2", "line xor mask",
              64'(line_o ^ mask_o), 64'(e.line));
        if (e.kind == KIND_ZERO)
          check(mask_o == '0, e.req, "mask zero", 64'(mask_o), 64'd0);
        else if (e.kind == KIND_ONES)
          check(mask_o == '1, e.req, "mask ones", 64'(mask_o), 64'(32'hFFFF_FFFF));
        flip_acc += $countones(mask_o);
      end
    end else if (rst_n) begin
      if (mask_o != '0) check(0, "R2", "idle mask", 64'(mask_o), 64'd0);
    end
  end

  task automatic send(input logic [LW-1:0] ln, input logic ap, input logic pth,
                      input logic se, input logic de, input logic [15:0] prm,
                      input logic [15:0] lst, input logic [15:0] nw,
                      input logic [31:0] slp, input int kind, input string req);
    exp_t e;
    valid_i = 1; line_i = ln; approx_i = ap; path_i = pth; st_en = se; dy_en = de;
    param_i = prm; last_i = lst; now_i = nw; slope_i = slp;
    e.line = ln; e.kind = kind; e.cyc = cyc; e.req = req;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic drain();
    valid_i = 0;
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic band(input int lo, input int hi, input string req, input string what);
    check(flip_acc >= lo && flip_acc <= hi, req, what, 64'(flip_acc), 64'((lo + hi) / 2));
  endtask

  initial begin
    #10000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(valid_o == 0 && line_o == '0 && mask_o == '0, "R10", "in reset",
          64'({valid_o, line_o}), 64'd0);
    rst_n = 1;
    @(negedge clk);
    check(valid_o == 0 && mask_o == '0, "R10", "after reset", 64'(valid_o), 64'd0);

    // R4/R5: extremes, back-to-back
    send(32'hDEAD_BEEF, 1, 0, 1, 0, 16'd1, 0, 0, 0, KIND_ONES, "R5");
    send(32'h1234_5678, 1, 0, 1, 0, 16'd0, 0, 0, 0, KIND_ONES, "R5");
    send(32'hCAFE_0001, 1, 1, 0, 1, 16'd5, 16'h10, 16'h10, 32'hFFFF_FFFF, KIND_ZERO, "R4");
    // R3: precise under most aggressive settings
    send(32'hA5A5_5A5A, 0, 0, 1, 1, 16'd1, 0, 16'h100, 32'hFFFF_FFFF, KIND_ZERO, "R3");
    send(32'h0F0F_F0F0, 0, 1, 1, 1, 16'd0, 0, 16'h1, 32'hFFFF_FFFF, KIND_ZERO, "R3");
    // R6: static on memory path does nothing
    send(32'h1111_2222, 1, 1, 1, 0, 16'd1, 0, 16'h50, 32'hFFFF_FFFF, KIND_ZERO, "R6");
    // R9: no mode
    send(32'h3333_4444, 1, 0, 0, 0, 16'd1, 0, 16'h50, 32'hFFFF_FFFF, KIND_ZERO, "R9");
    // R7: wrapped stamps, age 0x20 * 0x0800_0000 saturates
    send(32'h5555_6666, 1, 1, 0, 1, 16'd9, 16'hFFF0, 16'h0010, 32'h0800_0000, KIND_ONES, "R7");
    // R7: base plus ramp saturates (no overflow wrap)
    send(32'h7777_8888, 1, 0, 1, 1, 16'd1, 16'h0, 16'h0004, 32'h8000_0000, KIND_ONES, "R7");
    // R8: dynamic on memory path and cache path, age 0 adds nothing
    send(32'h9999_AAAA, 1, 1, 0, 1, 16'd1, 16'h2, 16'h3, 32'hFFFF_FFFF, KIND_ONES, "R8");
    send(32'hBBBB_CCCC, 1, 0, 0, 1, 16'd1, 16'h2, 16'h3, 32'hFFFF_FFFF, KIND_ONES, "R8");
    send(32'hDDDD_EEEE, 1, 0, 0, 1, 16'd1, 16'h7, 16'h7, 32'hFFFF_FFFF, KIND_ZERO, "R8");
    drain();

    // R5: statistics, 200 lines x 32 bits = 6400 bits
    flip_acc = 0;
    for (int i = 0; i < 200; i++) send(32'(i * 7919), 1, 0, 1, 0, 16'd2, 0, 0, 0, KIND_ANY, "R5");
    drain();
    band(2800, 3600, "R5", "param 2 flip count");
    flip_acc = 0;
    for (int i = 0; i < 200; i++) send(32'(i * 104729), 1, 0, 1, 0, 16'd8, 0, 0, 0, KIND_ANY, "R5");
    drain();
    band(550, 1050, "R5", "param 8 flip count");
    flip_acc = 0;
    for (int i = 0; i < 200; i++) send(32'(i), 1, 0, 1, 0, 16'hFFFF, 0, 0, 0, KIND_ANY, "R5");
    drain();
    band(0, 5, "R5", "param max flip count");
    // R7: age 0x40 * 2^24 = 2^30 -> about a quarter, memory path
    flip_acc = 0;
    for (int i = 0; i < 200; i++)
      send(32'(i * 31), 1, 1, 1, 1, 16'd1, 16'h0100, 16'h0140, 32'h0100_0000, KIND_ANY, "R7");
    drain();
    band(1300, 1900, "R7", "age-driven flip count");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule